// File: doc/BRIEF.md
# Shaped Tile Register File

This block keeps eight two-dimensional operand tiles for a matrix engine. Each tile is up to 16 rows deep and up to 64 bytes per row (16x32 two-byte elements or 16x64 one-byte elements). A single shape register, written by one shape-load command, gives every tile its own active row count and active row width in bytes. Rows are moved one at a time through a row port. A clear command wipes one tile so it can start a fresh accumulation.

The block also tracks whether the tile state is untouched. A small state machine has two states. ST_PRISTINE is entered at reset and after every shape load. ST_LIVE is entered from ST_PRISTINE by the first accepted row read, row write or tile clear. ST_LIVE returns to ST_PRISTINE only through a shape load. The `pristine` output lets context-switch logic skip saving state that was never touched.

When tile use is disabled, any command is refused with a one-cycle fault pulse and changes nothing. The requester is expected to enable tile use and retry. Every response appears on the cycle after the command is sampled.

Top module: `tilefile`

## Requirements
- R1: After reset, `pristine` is 1, `rsp_valid`, `rsp_fault` and `rsp_rowerr` are 0, and every tile has a row count of 0, so any row access is rejected as out of range.
- R2: A row write with the row index below the tile's row count stores the row. A later row read of that row raises `rsp_valid` for one cycle, one cycle after the command, and `rsp_data` holds the stored bytes.
- R3: A row read or write whose row index is at or above the selected tile's row count raises `rsp_rowerr` for one cycle, does not raise `rsp_valid`, and changes no tile contents and not `pristine`.
- R4: Byte b of a row (bits 8b+7..8b) reads as zero whenever b is at or above the tile's configured row width.
- R5: A clear command (op 2) makes every row of the selected tile read as zero and leaves the other tiles unchanged.
- R6: Any command issued while `tile_en` is 0 raises `rsp_fault` for one cycle. It does not raise `rsp_valid` or `rsp_rowerr`, and it changes no tile contents, no shape and not `pristine`.
- R7: `pristine` stays 1 until the first accepted row read, row write or clear, and is 0 in the cycle after it.
- R8: A shape load (op 3) makes every row of every tile read as zero and sets `pristine` to 1 in the next cycle.
- R9: In `cmd_shape`, tile t's row count is bits [12t+4:12t] and its row width is bits [12t+11:12t+5]. A row count above 16 acts as 16 and a width above 64 acts as 64. Each tile keeps its own shape.
- R10: A row that has not been written since the last clear of its tile or the last shape load reads as all zero.
- R11: Command ops are 0 row read, 1 row write, 2 tile clear, 3 shape load. Only one command is taken per cycle, when `cmd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_en | input | 1 | Tile use enabled |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 clear, 3 shape load |
| cmd_tile | input | 3 | Selected tile |
| cmd_row | input | 4 | Selected row |
| cmd_wdata | input | 512 | Row write data, byte b at bits 8b+7..8b |
| cmd_shape | input | 96 | Shape fields for all eight tiles |
| rsp_valid | output | 1 | Read data present |
| rsp_data | output | 512 | Read row |
| rsp_rowerr | output | 1 | Row index out of range pulse |
| rsp_fault | output | 1 | Tile use disabled fault pulse |
| pristine | output | 1 | Tile state untouched since reset or shape load |

## Verification
The hardest cases to reach are a refused command landing on state that has already been used. One example is a disabled read of a row holding data: the bench must show afterwards that the data and the ST_LIVE state both survived. Another is a shape load after the block has gone live, which must erase rows across tiles whose shapes differ. The stimulus first builds up distinct data in several tiles with different shapes. It then issues disabled commands, out-of-range rows, a clear and a fresh shape load against that state. A behavioural model follows every one of these steps and predicts all outputs on each clock.

// File: rtl/tilefile_pkg.sv
package tilefile_pkg;
    typedef enum logic [1:0] {
        OP_RDROW   = 2'd0,
        OP_WRROW   = 2'd1,
        OP_CLRTILE = 2'd2,
        OP_LDSHAPE = 2'd3
    } tile_op_e;

    typedef enum logic {
        ST_PRISTINE = 1'b0,
        ST_LIVE     = 1'b1
    } use_state_e;
endpackage

// File: rtl/tilefile_shape.sv
module tilefile_shape #(
    parameter int NUM_TILES = 8,
    parameter int MAX_ROWS  = 16,
    parameter int ROW_BYTES = 64,
    parameter int CNT_W     = 5,
    parameter int WID_W     = 7,
    localparam int FLD_W    = CNT_W + WID_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [NUM_TILES*FLD_W-1:0] shape_in,
    output logic [NUM_TILES*CNT_W-1:0] rows_o,
    output logic [NUM_TILES*WID_W-1:0] width_o
);
    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        logic [CNT_W-1:0] raw_rows;
        logic [WID_W-1:0] raw_wid;
        logic [CNT_W-1:0] rows_q;
        logic [WID_W-1:0] wid_q;

        assign raw_rows = shape_in[t*FLD_W +: CNT_W];
        assign raw_wid  = shape_in[t*FLD_W+CNT_W +: WID_W];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows_q <= '0;
                wid_q  <= '0;
            end else if (load) begin
                rows_q <= (raw_rows > CNT_W'(MAX_ROWS))  ? CNT_W'(MAX_ROWS)  : raw_rows;
                wid_q  <= (raw_wid  > WID_W'(ROW_BYTES)) ? WID_W'(ROW_BYTES) : raw_wid;
            end
        end

        assign rows_o[t*CNT_W +: CNT_W]  = rows_q;
        assign width_o[t*WID_W +: WID_W] = wid_q;
    end
endmodule

// File: rtl/tilefile_ctrl.sv
module tilefile_ctrl
    import tilefile_pkg::*;
#(
    parameter int NUM_TILES = 8,
    parameter int TILE_W    = 3,
    parameter int ROW_W     = 4,
    parameter int CNT_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tile_en,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [TILE_W-1:0]          cmd_tile,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic [NUM_TILES*CNT_W-1:0] rows_flat,
    output logic                       rd_go,
    output logic                       wr_go,
    output logic                       clr_go,
    output logic                       ld_go,
    output logic                       fault_o,
    output logic                       rowerr_o,
    output logic                       pristine_o
);
    use_state_e       state_q, state_d;
    tile_op_e         op;
    logic [CNT_W-1:0] sel_rows;
    logic             row_ok, live_cmd, refused, row_bad;

    assign op = tile_op_e'(cmd_op);

    always_comb begin
        sel_rows = '0;
        for (int t = 0; t < NUM_TILES; t++) begin
            if (cmd_tile == TILE_W'(t)) sel_rows = rows_flat[t*CNT_W +: CNT_W];
        end
    end

    assign row_ok   = CNT_W'(cmd_row) < sel_rows;
    assign live_cmd = cmd_valid && tile_en;
    assign refused  = cmd_valid && !tile_en;
    assign rd_go    = live_cmd && (op == OP_RDROW) && row_ok;
    assign wr_go    = live_cmd && (op == OP_WRROW) && row_ok;
    assign clr_go   = live_cmd && (op == OP_CLRTILE);
    assign ld_go    = live_cmd && (op == OP_LDSHAPE);
    assign row_bad  = live_cmd && ((op == OP_RDROW) || (op == OP_WRROW)) && !row_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRISTINE: if (!ld_go && (rd_go || wr_go || clr_go)) state_d = ST_LIVE;
            ST_LIVE:     if (ld_go) state_d = ST_PRISTINE;
            default:     state_d = ST_PRISTINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRISTINE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o  <= 1'b0;
            rowerr_o <= 1'b0;
        end else begin
            fault_o  <= refused;
            rowerr_o <= row_bad;
        end
    end

    assign pristine_o = (state_q == ST_PRISTINE);

    a_r6_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> (fault_o && !rowerr_o));
    a_r6_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> (state_q == $past(state_q)));
    a_r8_load_restores: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> pristine_o);
    a_r7_live_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!pristine_o && !ld_go) |=> !pristine_o);
    a_r7_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pristine_o && !live_cmd) |=> pristine_o);
    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_go, wr_go, clr_go, ld_go, row_bad, refused}) <= 1);
endmodule

// File: rtl/tilefile_rows.sv
module tilefile_rows #(
    parameter int NUM_TILES = 8,
    parameter int MAX_ROWS  = 16,
    parameter int ROW_BYTES = 64,
    parameter int TILE_W    = 3,
    parameter int ROW_W     = 4,
    parameter int WID_W     = 7,
    localparam int ROW_BITS = ROW_BYTES * 8,
    localparam int NUM_ENT  = NUM_TILES * MAX_ROWS,
    localparam int IDX_W    = $clog2(NUM_ENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_go,
    input  logic                       wr_go,
    input  logic                       clr_go,
    input  logic                       ld_go,
    input  logic [TILE_W-1:0]          tile,
    input  logic [ROW_W-1:0]           row,
    input  logic [ROW_BITS-1:0]        wdata,
    input  logic [NUM_TILES*WID_W-1:0] width_flat,
    output logic                       rsp_valid,
    output logic [ROW_BITS-1:0]        rsp_data
);
    logic [ROW_BITS-1:0] mem [NUM_ENT];
    logic [NUM_ENT-1:0]  row_live;
    logic [WID_W-1:0]    sel_wid;
    logic [ROW_BITS-1:0] byte_mask;
    logic [IDX_W-1:0]    idx;

    assign idx = IDX_W'(tile) * IDX_W'(MAX_ROWS) + IDX_W'(row);

    always_comb begin
        sel_wid = '0;
        for (int t = 0; t < NUM_TILES; t++) begin
            if (tile == TILE_W'(t)) sel_wid = width_flat[t*WID_W +: WID_W];
        end
    end

    always_comb begin
        for (int b = 0; b < ROW_BYTES; b++) begin
            byte_mask[b*8 +: 8] = (WID_W'(b) < sel_wid) ? 8'hFF : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[idx] <= wdata & byte_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_live <= '0;
        end else begin
            for (int e = 0; e < NUM_ENT; e++) begin
                if (ld_go || (clr_go && ((e / MAX_ROWS) == int'(tile)))) row_live[e] <= 1'b0;
            end
            if (wr_go) row_live[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_go;
            if (rd_go) rsp_data <= row_live[idx] ? (mem[idx] & byte_mask) : '0;
        end
    end

    a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rsp_valid);
    a_r2_no_spurious_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rsp_valid);
    a_r8_load_wipes_all: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> (row_live == '0));
endmodule

// File: rtl/tilefile.sv
module tilefile
    import tilefile_pkg::*;
#(
    parameter int NUM_TILES  = 8,
    parameter int MAX_ROWS   = 16,
    parameter int ROW_BYTES  = 64,
    localparam int TILE_W    = $clog2(NUM_TILES),
    localparam int ROW_W     = $clog2(MAX_ROWS),
    localparam int CNT_W     = $clog2(MAX_ROWS + 1),
    localparam int WID_W     = $clog2(ROW_BYTES + 1),
    localparam int ROW_BITS  = ROW_BYTES * 8,
    localparam int SHAPE_W   = NUM_TILES * (CNT_W + WID_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tile_en,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [TILE_W-1:0]   cmd_tile,
    input  logic [ROW_W-1:0]    cmd_row,
    input  logic [ROW_BITS-1:0] cmd_wdata,
    input  logic [SHAPE_W-1:0]  cmd_shape,
    output logic                rsp_valid,
    output logic [ROW_BITS-1:0] rsp_data,
    output logic                rsp_rowerr,
    output logic                rsp_fault,
    output logic                pristine
);
    logic [NUM_TILES*CNT_W-1:0] rows_flat;
    logic [NUM_TILES*WID_W-1:0] width_flat;
    logic rd_go, wr_go, clr_go, ld_go;

    tilefile_ctrl #(
        .NUM_TILES(NUM_TILES), .TILE_W(TILE_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tile_en(tile_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_tile(cmd_tile), .cmd_row(cmd_row),
        .rows_flat(rows_flat), .rd_go(rd_go), .wr_go(wr_go), .clr_go(clr_go),
        .ld_go(ld_go), .fault_o(rsp_fault), .rowerr_o(rsp_rowerr),
        .pristine_o(pristine)
    );

    tilefile_shape #(
        .NUM_TILES(NUM_TILES), .MAX_ROWS(MAX_ROWS), .ROW_BYTES(ROW_BYTES),
        .CNT_W(CNT_W), .WID_W(WID_W)
    ) u_shape (
        .clk(clk), .rst_n(rst_n), .load(ld_go), .shape_in(cmd_shape),
        .rows_o(rows_flat), .width_o(width_flat)
    );

    tilefile_rows #(
        .NUM_TILES(NUM_TILES), .MAX_ROWS(MAX_ROWS), .ROW_BYTES(ROW_BYTES),
        .TILE_W(TILE_W), .ROW_W(ROW_W), .WID_W(WID_W)
    ) u_rows (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go), .clr_go(clr_go),
        .ld_go(ld_go), .tile(cmd_tile), .row(cmd_row), .wdata(cmd_wdata),
        .width_flat(width_flat), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    a_r3_err_excludes_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rowerr |-> !rsp_valid);
    a_r6_fault_excludes_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_valid && !rsp_rowerr));
endmodule

// File: tb/test_tilefile.sv
`timescale 1ns/1ps
module test_tilefile;
    localparam int NT = 8, MR = 16, RB = 64;

    logic         clk = 1'b0;
    logic         rst_n, tile_en, cmd_valid;
    logic [1:0]   cmd_op;
    logic [2:0]   cmd_tile;
    logic [3:0]   cmd_row;
    logic [511:0] cmd_wdata;
    logic [95:0]  cmd_shape;
    logic         rsp_valid, rsp_rowerr, rsp_fault, pristine;
    logic [511:0] rsp_data;

    always #4 clk = ~clk;

    tilefile i_tilefile (
        .clk(clk), .rst_n(rst_n), .tile_en(tile_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_tile(cmd_tile), .cmd_row(cmd_row),
        .cmd_wdata(cmd_wdata), .cmd_shape(cmd_shape), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_rowerr(rsp_rowerr), .rsp_fault(rsp_fault),
        .pristine(pristine)
    );

    logic [511:0] m_mem [NT][MR];
    int m_rows [NT];
    int m_wid  [NT];
    bit m_pristine;
    int n_tests = 0, n_fail = 0;

    task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] wmask(int w);
        logic [511:0] m = '0;
        for (int b = 0; b < RB; b++) if (b < w) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [511:0] pat(int s);
        logic [511:0] p;
        for (int k = 0; k < 16; k++)
            p[k*32 +: 32] = 32'(s) * 32'h9E37_79B1 + 32'(k) * 32'h0101_0101 + 32'h5A5A_0000;
        return p;
    endfunction

    function automatic logic [95:0] fld(int t, int r, int w);
        logic [95:0] v = '0;
        v[t*12 +: 5]     = 5'(r);
        v[t*12 + 5 +: 7] = 7'(w);
        return v;
    endfunction

    // one command per clock, model predicts, outputs compared next clock
    task automatic cmd(string req, int op, int t, int r, logic [511:0] d,
                       logic [95:0] shp, bit en);
        bit ev = 0, ee = 0, ef = 0;
        logic [511:0] ed = '0;
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_tile = 3'(t); cmd_row = 4'(r);
        cmd_wdata = d; cmd_shape = shp; tile_en = en;
        if (!en) ef = 1;
        else begin
            case (op)
                0: if (r < m_rows[t]) begin
                       ev = 1; ed = m_mem[t][r] & wmask(m_wid[t]); m_pristine = 0;
                   end else ee = 1;
                1: if (r < m_rows[t]) begin
                       m_mem[t][r] = d & wmask(m_wid[t]); m_pristine = 0;
                   end else ee = 1;
                2: begin
                       for (int rr = 0; rr < MR; rr++) m_mem[t][rr] = '0;
                       m_pristine = 0;
                   end
                default: begin
                       for (int tt = 0; tt < NT; tt++) begin
                           int rv = int'(shp[tt*12 +: 5]);
                           int wv = int'(shp[tt*12 + 5 +: 7]);
                           m_rows[tt] = (rv > MR) ? MR : rv;
                           m_wid[tt]  = (wv > RB) ? RB : wv;
                           for (int rr = 0; rr < MR; rr++) m_mem[tt][rr] = '0;
                       end
                       m_pristine = 1;
                   end
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "rsp_valid",  512'(rsp_valid),  512'(ev));
        chk(req, "rsp_rowerr", 512'(rsp_rowerr), 512'(ee));
        chk(req, "rsp_fault",  512'(rsp_fault),  512'(ef));
        chk(req, "pristine",   512'(pristine),   512'(m_pristine));
        if (ev) chk(req, "rsp_data", rsp_data, ed);
    endtask

    task automatic rd(string req, int t, int r);
        cmd(req, 0, t, r, '0, '0, 1'b1);
    endtask
    task automatic wr(string req, int t, int r, logic [511:0] d);
        cmd(req, 1, t, r, d, '0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [95:0] shp;
        rst_n = 1'b0; tile_en = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
        cmd_tile = '0; cmd_row = '0; cmd_wdata = '0; cmd_shape = '0;
        for (int t = 0; t < NT; t++) begin
            m_rows[t] = 0; m_wid[t] = 0;
            for (int r = 0; r < MR; r++) m_mem[t][r] = '0;
        end
        m_pristine = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "pristine", 512'(pristine), 512'(1));
        chk("R1", "rsp_valid", 512'(rsp_valid), 512'(0));
        chk("R1", "rsp_fault", 512'(rsp_fault), 512'(0));
        chk("R1", "rsp_rowerr", 512'(rsp_rowerr), 512'(0));
        rd("R1", 0, 0);
        wr("R1", 5, 0, pat(1));
        // R6 refused while disabled
        cmd("R6", 1, 0, 0, pat(2), '0, 1'b0);
        cmd("R6", 3, 0, 0, '0, fld(0, 16, 64), 1'b0);
        // R9 per-tile shapes, clamping
        shp = fld(0, 16, 64) | fld(1, 4, 10) | fld(2, 1, 1) | fld(3, 16, 0)
            | fld(4, 31, 127) | fld(5, 8, 32) | fld(6, 2, 2) | fld(7, 0, 64);
        cmd("R8", 3, 0, 0, '0, shp, 1'b1);
        cmd("R6", 1, 0, 0, pat(3), '0, 1'b0);
        rd("R7", 0, 0);
        wr("R2", 0, 3, pat(4));
        rd("R2", 0, 3);
        wr("R4", 1, 2, pat(5));
        rd("R4", 1, 2);
        wr("R3", 1, 4, pat(6));
        rd("R3", 1, 4);
        rd("R10", 1, 3);
        wr("R9", 4, 15, pat(7));
        rd("R9", 4, 15);
        wr("R4", 3, 0, pat(8));
        rd("R4", 3, 0);
        wr("R9", 2, 0, pat(9));
        rd("R9", 2, 0);
        rd("R3", 2, 1);
        rd("R3", 7, 0);
        // R6 refused read keeps data and live state
        cmd("R6", 0, 0, 3, '0, '0, 1'b0);
        cmd("R6", 2, 0, 0, '0, '0, 1'b0);
        rd("R6", 0, 3);
        for (int r = 0; r < 8; r++) wr("R2", 5, r, pat(20 + r));
        for (int r = 7; r >= 0; r--) rd("R2", 5, r);
        wr("R2", 6, 1, '1);
        rd("R2", 6, 1);
        // R5 clear one tile only
        cmd("R5", 2, 0, 0, '0, '0, 1'b1);
        rd("R5", 0, 3);
        rd("R5", 1, 2);
        rd("R5", 5, 4);
        // R8 shape load wipes everything and restores pristine
        cmd("R8", 3, 0, 0, '0, shp, 1'b1);
        rd("R8", 1, 2);
        rd("R8", 5, 4);
        cmd("R8", 3, 0, 0, '0, shp, 1'b1);
        cmd("R7", 2, 3, 0, '0, '0, 1'b1);
        cmd("R11", 1, 0, 1, pat(40), '0, 1'b1);
        rd("R11", 0, 1);
        rd("R11", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule